// File: doc/BRIEF.md
# Transport Header Anomaly Checker

This block inspects the transport-layer summary of one parsed packet and reduces it to a single 4-bit exception code. An upstream parser presents the protocol kind (TCP or UDP), the number of bytes that remain after the IP header, the transport length field, the length implied by the IP header, both port numbers, the TCP flag byte and a checksum-good indication. It raises a valid strobe for one cycle. The block captures these inputs only on that strobe and returns the code one cycle later, together with its own valid strobe.

The block checks three things: whether the lengths make sense, whether either port is zero, and whether the TCP flags form a combination that no legal segment uses. When several faults are present, a fixed priority chooses the one code that is reported. The block does not compute the checksum. It does not parse the IP header, and it does not discard packets. Downstream logic acts on the code.

Top module: `l4_anom_top`

## Requirements
- R1: One cycle after `in_vld` is high at a rising edge, `res_vld` is high for exactly one cycle and `res_code` holds the code for the inputs sampled at that edge. Without `in_vld`, `res_vld` stays low and `res_code` keeps its last value. After reset, `res_vld` is 0 and `res_code` is 0.
- R2: Code 1 is reported when `avail_len` is smaller than the header size. The header size is 20 bytes for TCP (`is_tcp`=1) and 8 bytes for UDP (`is_tcp`=0). Code 1 has the highest priority.
- R3: Code 3 is reported when `l4_len` differs from `ip_l4_len`. Among the remaining faults this has the highest priority.
- R4: Code 2 is reported when `csum_ok` is 0 and no higher fault is present.
- R5: Code 4 is reported when `src_port` or `dst_port` is zero and no higher fault is present.
- R6: The flag byte uses the bit positions FIN=0, SYN=1, RST=2, PSH=3, ACK=4, URG=5. For TCP, and with no higher fault, the codes are checked in this order: 8 when the byte equals only FIN (0x01), 9 when the byte is 0x00, 10 when both FIN and RST are set, 11 when both SYN and URG are set, 12 when both SYN and RST are set, and 13 when both SYN and FIN are set. The first match wins.
- R7: For UDP the flag byte has no effect, so the code is always one of 0 to 4.
- R8: The block never reports codes 5, 6, 7 or any value above 13. Code 0 means no fault was found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Marks a packet summary to check |
| is_tcp | input | 1 | 1 = TCP, 0 = UDP |
| avail_len | input | 16 | Bytes available after the IP header |
| l4_len | input | 16 | Transport length field |
| ip_l4_len | input | 16 | Transport length implied by the IP header |
| src_port | input | 16 | Source port |
| dst_port | input | 16 | Destination port |
| tcp_flags | input | 8 | TCP flag byte |
| csum_ok | input | 1 | Checksum verified good |
| res_vld | output | 1 | Result strobe |
| res_code | output | 4 | Exception code |

## Verification
The hardest codes to reach are the ones at the bottom of the priority chain, codes 12 and 13. They are only reported when every length, checksum, port and earlier flag check passes. They also need a flag byte that avoids FIN-only, zero, FIN+RST and SYN+URG. Uniform random stimulus rarely meets all of these at once. The bench therefore biases its random draws toward consistent lengths, a good checksum and nonzero ports, and builds its flag bytes from a small set of SYN/FIN/RST/URG combinations. It also adds directed cases in which exactly one lower-priority fault is present and one in which faults at every level are present together.

// File: rtl/l4_anom_pkg.sv
package l4_anom_pkg;
    localparam int unsigned LEN_W  = 16;
    localparam int unsigned PORT_W = 16;
    localparam int unsigned CODE_W = 4;
    localparam int unsigned TCP_HDR = 20;
    localparam int unsigned UDP_HDR = 8;

    localparam int unsigned FLG_FIN = 0;
    localparam int unsigned FLG_SYN = 1;
    localparam int unsigned FLG_RST = 2;
    localparam int unsigned FLG_URG = 5;

    typedef enum logic [CODE_W-1:0] {
        EXC_NONE      = 4'd0,
        EXC_SHORT     = 4'd1,
        EXC_CSUM      = 4'd2,
        EXC_LEN_MIS   = 4'd3,
        EXC_ZERO_PORT = 4'd4,
        EXC_FIN_ONLY  = 4'd8,
        EXC_NO_FLAGS  = 4'd9,
        EXC_FIN_RST   = 4'd10,
        EXC_SYN_URG   = 4'd11,
        EXC_SYN_RST   = 4'd12,
        EXC_SYN_FIN   = 4'd13
    } exc_code_e;

    typedef struct packed {
        logic      vld;
        exc_code_e code;
    } res_state_t;
endpackage

// File: rtl/l4_len_chk.sv
module l4_anom_len_chk
    import l4_anom_pkg::*;
#(
    parameter int unsigned LW = LEN_W
) (
    input  logic          is_tcp,
    input  logic [LW-1:0] avail_len,
    input  logic [LW-1:0] l4_len,
    input  logic [LW-1:0] ip_l4_len,
    output logic          too_short,
    output logic          mismatch
);
    localparam logic [LW-1:0] TCP_MIN = LW'(TCP_HDR);
    localparam logic [LW-1:0] UDP_MIN = LW'(UDP_HDR);

    logic [LW-1:0] need;

    always_comb begin
        need      = is_tcp ? TCP_MIN : UDP_MIN;
        too_short = avail_len < need;
        mismatch  = l4_len != ip_l4_len;
    end
endmodule

// File: rtl/l4_flag_chk.sv
module l4_anom_flag_chk
    import l4_anom_pkg::*;
(
    input  logic       is_tcp,
    input  logic [7:0] flags,
    output logic       flag_hit,
    output exc_code_e  flag_code
);
    localparam int unsigned NRULE = 6;

    logic [NRULE-1:0] hit;
    exc_code_e        rule_code [NRULE];

    always_comb begin
        hit[0] = flags == 8'h01;
        hit[1] = flags == 8'h00;
        hit[2] = flags[FLG_FIN] & flags[FLG_RST];
        hit[3] = flags[FLG_SYN] & flags[FLG_URG];
        hit[4] = flags[FLG_SYN] & flags[FLG_RST];
        hit[5] = flags[FLG_SYN] & flags[FLG_FIN];
        rule_code[0] = EXC_FIN_ONLY;
        rule_code[1] = EXC_NO_FLAGS;
        rule_code[2] = EXC_FIN_RST;
        rule_code[3] = EXC_SYN_URG;
        rule_code[4] = EXC_SYN_RST;
        rule_code[5] = EXC_SYN_FIN;
    end

    // lowest index wins: scan from the back so earlier rules overwrite
    always_comb begin
        flag_hit  = 1'b0;
        flag_code = EXC_NONE;
        for (int i = NRULE - 1; i >= 0; i--) begin
            if (is_tcp && hit[i]) begin
                flag_hit  = 1'b1;
                flag_code = rule_code[i];
            end
        end
    end
endmodule

// File: rtl/l4_anom_top.sv
module l4_anom_top
    import l4_anom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              is_tcp,
    input  logic [LEN_W-1:0]  avail_len,
    input  logic [LEN_W-1:0]  l4_len,
    input  logic [LEN_W-1:0]  ip_l4_len,
    input  logic [PORT_W-1:0] src_port,
    input  logic [PORT_W-1:0] dst_port,
    input  logic [7:0]        tcp_flags,
    input  logic              csum_ok,
    output logic              res_vld,
    output logic [CODE_W-1:0] res_code
);
    logic      too_short, mismatch, flag_hit;
    exc_code_e flag_code;
    res_state_t st_d, st_q;

    l4_anom_len_chk #(.LW(LEN_W)) len_i (
        .is_tcp    (is_tcp),
        .avail_len (avail_len),
        .l4_len    (l4_len),
        .ip_l4_len (ip_l4_len),
        .too_short (too_short),
        .mismatch  (mismatch)
    );

    l4_anom_flag_chk flag_i (
        .is_tcp    (is_tcp),
        .flags     (tcp_flags),
        .flag_hit  (flag_hit),
        .flag_code (flag_code)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            if (too_short)
                st_d.code = EXC_SHORT;
            else if (mismatch)
                st_d.code = EXC_LEN_MIS;
            else if (!csum_ok)
                st_d.code = EXC_CSUM;
            else if (src_port == '0 || dst_port == '0)
                st_d.code = EXC_ZERO_PORT;
            else if (flag_hit)
                st_d.code = flag_code;
            else
                st_d.code = EXC_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{vld: 1'b0, code: EXC_NONE};
        else        st_q <= st_d;
    end

    assign res_vld  = st_q.vld;
    assign res_code = st_q.code;

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> res_vld); // R1
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(res_code)); // R1
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_code inside {4'd5, 4'd6, 4'd7}) && res_code <= 4'd13); // R8
    AST_UDP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !is_tcp) |=> res_code <= 4'd4); // R7
    AST_SHORT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && too_short) |=> res_code == 4'd1); // R2
endmodule

// File: tb/l4_anom_tb.sv
module l4_anom_top_tb_top;
    logic clk = 0, rst_n = 0;
    logic in_vld = 0, is_tcp = 0, csum_ok = 0;
    logic [15:0] avail_len = 0, l4_len = 0, ip_l4_len = 0, src_port = 0, dst_port = 0;
    logic [7:0] tcp_flags = 0;
    logic res_vld;
    logic [3:0] res_code;
    int n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    l4_anom_top dut_i (.*);

    function automatic logic [3:0] ref_code(logic t, logic [15:0] av, logic [15:0] l4,
            logic [15:0] ip, logic [15:0] sp, logic [15:0] dp, logic [7:0] f, logic ck);
        if (av < (t ? 16'd20 : 16'd8)) return 4'd1;
        if (l4 != ip) return 4'd3;
        if (!ck) return 4'd2;
        if (sp == 0 || dp == 0) return 4'd4;
        if (!t) return 4'd0;
        if (f == 8'h01) return 4'd8;
        if (f == 8'h00) return 4'd9;
        if (f[0] && f[2]) return 4'd10;
        if (f[1] && f[5]) return 4'd11;
        if (f[1] && f[2]) return 4'd12;
        if (f[1] && f[0]) return 4'd13;
        return 4'd0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply(string req, logic t, logic [15:0] av, logic [15:0] l4, logic [15:0] ip,
            logic [15:0] sp, logic [15:0] dp, logic [7:0] f, logic ck);
        logic [3:0] exp;
        exp = ref_code(t, av, l4, ip, sp, dp, f, ck);
        @(negedge clk);
        in_vld = 1; is_tcp = t; avail_len = av; l4_len = l4; ip_l4_len = ip;
        src_port = sp; dst_port = dp; tcp_flags = f; csum_ok = ck;
        @(negedge clk);
        in_vld = 0;
        tcp_flags = ~f; avail_len = 0; csum_ok = ~ck;
        check(req, res_vld, 1);
        check(req, res_code, exp);
        if (exp inside {4'd5, 4'd6, 4'd7} || exp > 13) check("R8", exp, 0);
    endtask

    initial begin : wd
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=hang expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] fl [8];
        logic [3:0] held;
        void'($urandom(32'd4242));
        fl = '{8'h01, 8'h00, 8'h05, 8'h22, 8'h06, 8'h03, 8'h12, 8'h18};
        @(negedge clk);
        check("R1 reset vld", res_vld, 0);
        check("R1 reset code", res_code, 0);
        rst_n = 1;
        apply("R2 tcp short",   1, 19, 50, 50, 1, 1, 8'h12, 1);
        apply("R2 tcp exact",   1, 20, 50, 50, 1, 1, 8'h12, 1);
        apply("R2 udp short",   0, 7, 5, 6, 0, 0, 8'h00, 0);
        apply("R2 all faults",  1, 3, 5, 6, 0, 0, 8'h07, 0);
        apply("R3 mismatch",    0, 40, 30, 31, 0, 5, 8'h00, 0);
        apply("R4 csum",        1, 40, 30, 30, 0, 5, 8'h01, 0);
        apply("R5 src zero",    1, 40, 30, 30, 0, 5, 8'h03, 1);
        apply("R5 dst zero",    0, 40, 30, 30, 7, 0, 8'h00, 1);
        apply("R6 fin only",    1, 40, 30, 30, 7, 9, 8'h01, 1);
        apply("R6 none",        1, 40, 30, 30, 7, 9, 8'h00, 1);
        apply("R6 fin rst",     1, 40, 30, 30, 7, 9, 8'h07, 1);
        apply("R6 syn urg",     1, 40, 30, 30, 7, 9, 8'h23, 1);
        apply("R6 syn rst",     1, 40, 30, 30, 7, 9, 8'h16, 1);
        apply("R6 syn fin",     1, 40, 30, 30, 7, 9, 8'h13, 1);
        apply("R6 clean ack",   1, 40, 30, 30, 7, 9, 8'h10, 1);
        apply("R7 udp flags",   0, 40, 30, 30, 7, 9, 8'h00, 1);
        apply("R7 udp fin",     0, 40, 30, 30, 7, 9, 8'h01, 1);
        held = res_code;
        repeat (3) begin
            @(negedge clk);
            check("R1 idle vld", res_vld, 0);
            check("R1 idle hold", res_code, held);
        end
        for (int i = 0; i < 400; i++) begin
            logic [15:0] l;
            l = 16'($urandom_range(0, 60));
            apply("R6 random", 1'($urandom),
                  ($urandom_range(0, 9) == 0) ? 16'($urandom_range(0, 25)) : 16'($urandom_range(20, 80)),
                  l, ($urandom_range(0, 9) == 0) ? l + 1 : l,
                  ($urandom_range(0, 9) == 0) ? 16'd0 : 16'($urandom_range(1, 65535)),
                  ($urandom_range(0, 9) == 0) ? 16'd0 : 16'($urandom_range(1, 65535)),
                  ($urandom_range(0, 1) == 0) ? fl[$urandom_range(0, 7)] : 8'($urandom),
                  ($urandom_range(0, 9) != 0));
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule